// File: doc/BRIEF.md
# UART Receive Byte Queue with Trigger and Idle Timeout

This block buffers received characters for a 16550-style serial port. A deserializer hands it one byte per cycle on `rx_valid`/`rx_data`, or a break event on `rx_break`. The host side takes bytes with a one-cycle `rd_en` pulse, and `rd_data` shows the byte that pulse removes. The block keeps the line-status flags that belong to the receive path: data available, break seen and overrun. It also produces a trigger flag for the interrupt arbiter and a character-timeout flag, which rises when data has been left untouched for four character times.

The input has no back-pressure and no ready signal. The block takes every byte presented with `rx_valid` high. When there is no room, the byte is dropped and the overrun flag records the loss, so the upstream deserializer never stalls. Control arrives as writes of the FIFO control byte on `fcr_wr`/`fcr_data`. Bit 0 enables the 16-entry queue, bit 1 empties the receive queue, bit 2 requests a transmit queue flush, and bits 7:6 select the trigger depth. The current character time, counted in clock cycles, arrives on `char_time`, which must be at least 1. With the queue disabled the block behaves as a single holding register.

Top module: `uart_rx_queue`

## Requirements
- R1: With the queue enabled, `trig_hit` is high exactly when `fifo_level` is at or above the trigger depth, which is set by `fcr_data[7:6]` on an enabling control write: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R2: A byte or break that arrives while the store is full and no read takes place in the same cycle is discarded. `overrun` is set, and the stored bytes and their order are unchanged.
- R3: A control write with bit 1 set empties the receive store and clears `timeout_pend`. A byte arriving in the same cycle is dropped.
- R4: A control write whose bit 0 differs from the current enable state empties the receive store and raises `tx_flush`. A control write with bit 2 set also raises `tx_flush`. `tx_flush` is high only during the cycle of such a write.
- R5: With the queue enabled and data held, `timeout_pend` rises 4×`char_time` cycles after the last byte stored, read request or flush, and each of these events restarts the count.
- R6: Any read request clears `timeout_pend`. `data_ready` is high exactly when the store is non-empty. `break_ind` clears when a read empties the store.
- R7: A break event stores the byte 0x00 and sets `break_ind` and `data_ready`.
- R8: With the queue disabled, the store holds one byte. A second arrival while it is held sets `overrun` and keeps the first byte, `trig_hit` follows `data_ready`, and `timeout_pend` never rises.
- R9: An `lsr_rd` pulse clears `break_ind` and `overrun`. A new break or overrun in the same cycle takes priority over the clear.
- R10: A read request while the store is empty returns 0x00 on `rd_data` and leaves `fifo_level` at 0.
- R11: A byte and a read in the same cycle leave `fifo_level` unchanged. This holds even when the store is full, and in that case no overrun is recorded.
- R12: After reset the queue is disabled, the trigger depth is 1, `fifo_level` is 0, and all status outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break condition detected this cycle |
| rd_en | input | 1 | Host read of the receive buffer |
| rd_data | output | 8 | Byte returned by the read (0x00 when empty) |
| lsr_rd | input | 1 | Host read of line status; clears break and overrun |
| fcr_wr | input | 1 | Write strobe for the FIFO control byte |
| fcr_data | input | 8 | FIFO control byte |
| char_time | input | 16 | Character time in clock cycles (at least 1) |
| tx_flush | output | 1 | Transmit queue must be emptied this cycle |
| fifo_level | output | 5 | Bytes currently stored |
| data_ready | output | 1 | Store is non-empty |
| break_ind | output | 1 | Break indication |
| overrun | output | 1 | Overrun indication |
| timeout_pend | output | 1 | Character timeout pending |
| trig_hit | output | 1 | Fill level at or above trigger depth |
| fifo_on | output | 1 | Queue enable state |

## Verification
`rd_data` and `tx_flush` are combinational, so they are due in the same cycle as the `rd_en` or `fcr_wr` that produces them. The bench samples them one time unit after driving, well before the next rising edge. Every stored effect (level, flags, enable, trigger) is due one edge after its stimulus, and the bench reads these at the falling edge that follows. The timeout is due 4×`char_time` edges after its restarting event. With `char_time` = 2, the bench confirms the flag is still low after the seventh edge and high after the eighth.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'b00,
    TRIG_FOUR = 2'b01,
    TRIG_EIGHT = 2'b10,
    TRIG_FOURTEEN = 2'b11
  } trig_sel_e;

  // index of each status flag inside the flag bank
  localparam int FLAG_BRK = 0;
  localparam int FLAG_OVR = 1;
  localparam int FLAG_TMO = 2;
  localparam int NFLAGS   = 3;

  function automatic int trig_depth(input trig_sel_e sel);
    case (sel)
      TRIG_ONE:   return 1;
      TRIG_FOUR:  return 4;
      TRIG_EIGHT: return 8;
      default:    return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [CW-1:0] level
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= step_ptr(wr_ptr);
      if (pop)  rd_ptr <= step_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end

  assign head = mem[rd_ptr];

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |-> (level != CW'(DEPTH)));

  assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> (level != '0));

  assert_pair_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !flush) |=> $stable(level));

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int CTW = 16,
  localparam int TW = CTW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           run,
  input  logic [CTW-1:0] char_time,
  output logic           expire
);

  logic [TW-1:0] ticks;
  logic [TW-1:0] last_tick;

  // four character times, minus one for the zero-based count
  assign last_tick = {char_time, 2'b00} - TW'(1);
  assign expire    = run && !restart && (ticks == last_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ticks <= '0;
    else if (restart)                       ticks <= '0;
    else if (run && ticks != last_tick)     ticks <= ticks + TW'(1);
  end

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CTW   = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_valid,
  input  logic [DW-1:0]  rx_data,
  input  logic           rx_break,
  input  logic           rd_en,
  output logic [DW-1:0]  rd_data,
  input  logic           lsr_rd,
  input  logic           fcr_wr,
  input  logic [7:0]     fcr_data,
  input  logic [CTW-1:0] char_time,
  output logic           tx_flush,
  output logic [CW-1:0]  fifo_level,
  output logic           data_ready,
  output logic           break_ind,
  output logic           overrun,
  output logic           timeout_pend,
  output logic           trig_hit,
  output logic           fifo_on
);

  trig_sel_e      trig_sel;
  logic           en_q;
  logic [DW-1:0]  head;
  logic [CW-1:0]  level;
  logic           toggle, flush, arrive, full, pop, push, lose;
  logic           drains, expire;
  logic [NFLAGS-1:0] fset, fclr, fq;

  // control byte decode
  assign toggle   = fcr_wr && (fcr_data[0] != en_q);
  assign flush    = fcr_wr && (fcr_data[1] || toggle);
  assign tx_flush = fcr_wr && (fcr_data[2] || toggle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      trig_sel <= TRIG_ONE;
    end else if (fcr_wr) begin
      en_q <= fcr_data[0];
      if (fcr_data[0]) trig_sel <= trig_sel_e'(fcr_data[7:6]);
    end
  end

  // admission: capacity is the full depth when enabled, one byte otherwise
  assign arrive = (rx_valid || rx_break) && !flush;
  assign full   = en_q ? (level == CW'(DEPTH)) : (level != '0);
  assign pop    = rd_en && (level != '0) && !flush;
  assign push   = arrive && (!full || pop);
  assign lose   = arrive && full && !pop;
  assign drains = pop && !push && (level == CW'(1));

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .pop   (pop),
    .wdata (rx_break ? '0 : rx_data),
    .head  (head),
    .level (level)
  );

  rxq_idle_timer #(.CTW(CTW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (push || rd_en || flush),
    .run       (en_q && (level != '0) && !fq[FLAG_TMO]),
    .char_time (char_time),
    .expire    (expire)
  );

  always_comb begin
    fset = '0;
    fclr = '0;
    fset[FLAG_BRK] = rx_break && !flush;
    fclr[FLAG_BRK] = lsr_rd || flush || drains;
    fset[FLAG_OVR] = lose;
    fclr[FLAG_OVR] = lsr_rd;
    fset[FLAG_TMO] = expire;
    fclr[FLAG_TMO] = rd_en || flush;
  end

  rxq_flags #(.N(NFLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (fset),
    .clr   (fclr),
    .q     (fq)
  );

  assign rd_data      = (level != '0) ? head : '0;
  assign fifo_level   = level;
  assign data_ready   = (level != '0);
  assign break_ind    = fq[FLAG_BRK];
  assign overrun      = fq[FLAG_OVR];
  assign timeout_pend = fq[FLAG_TMO];
  assign fifo_on      = en_q;
  assign trig_hit     = en_q ? (int'(level) >= trig_depth(trig_sel)) : (level != '0);

  assert_flush_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fifo_level == '0 && !timeout_pend));

  assert_tmo_with_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_pend) |-> (fifo_level != '0 && fifo_on));

  assert_ovr_keeps_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $stable(fifo_level));

  assert_lsr_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_valid && !rx_break) |=> (!overrun && !break_ind));

  assert_no_tmo_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_on |=> !$rose(timeout_pend));

endmodule

// File: tb/tb_uart_rx_queue.sv
module tb_uart_rx_queue;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_PUSH = 2'd0, OP_READ = 2'd1, OP_BRK = 2'd2, OP_FCR = 2'd3;

  // {op[2], data[8], level[5], read byte[8], trig[1]}
  localparam logic [23:0] VEC [12] = '{
    {OP_FCR,  8'h41, 5'd0, 8'h00, 1'b0},
    {OP_PUSH, 8'h11, 5'd1, 8'h00, 1'b0},
    {OP_PUSH, 8'h22, 5'd2, 8'h00, 1'b0},
    {OP_PUSH, 8'h33, 5'd3, 8'h00, 1'b0},
    {OP_BRK,  8'h00, 5'd4, 8'h00, 1'b1},
    {OP_READ, 8'h00, 5'd3, 8'h11, 1'b0},
    {OP_READ, 8'h00, 5'd2, 8'h22, 1'b0},
    {OP_READ, 8'h00, 5'd1, 8'h33, 1'b0},
    {OP_READ, 8'h00, 5'd0, 8'h00, 1'b0},
    {OP_READ, 8'h00, 5'd0, 8'h00, 1'b0},
    {OP_PUSH, 8'hA5, 5'd1, 8'h00, 1'b0},
    {OP_FCR,  8'h43, 5'd0, 8'h00, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_break = 0, rd_en = 0, lsr_rd = 0, fcr_wr = 0;
  logic [7:0] rx_data = 0, fcr_data = 0, rd_data;
  logic [15:0] char_time = 16'd2;
  logic tx_flush, data_ready, break_ind, overrun, timeout_pend, trig_hit, fifo_on;
  logic [4:0] fifo_level;
  logic [7:0] got_rd;
  logic got_tx;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_queue dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .rd_en(rd_en), .rd_data(rd_data), .lsr_rd(lsr_rd),
    .fcr_wr(fcr_wr), .fcr_data(fcr_data), .char_time(char_time),
    .tx_flush(tx_flush), .fifo_level(fifo_level), .data_ready(data_ready),
    .break_ind(break_ind), .overrun(overrun), .timeout_pend(timeout_pend),
    .trig_hit(trig_hit), .fifo_on(fifo_on)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive one cycle just after a falling edge, capture combinational outputs,
  // release at the next falling edge (state already updated by the rising edge)
  task automatic step(input logic p, input logic r, input logic b,
                      input logic f, input logic l, input logic [7:0] d);
    rx_valid = p; rd_en = r; rx_break = b; fcr_wr = f; lsr_rd = l;
    rx_data = d; fcr_data = d;
    #1;
    got_rd = rd_data;
    got_tx = tx_flush;
    @(negedge clk);
    rx_valid = 0; rd_en = 0; rx_break = 0; fcr_wr = 0; lsr_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 level", int'(fifo_level), 0);
    chk("R12 fifo_on", int'(fifo_on), 0);
    chk("R12 flags", int'({data_ready, break_ind, overrun, timeout_pend, trig_hit}), 0);

    // vector table walk
    for (int i = 0; i < 12; i++) begin
      logic [1:0] op;
      op = VEC[i][23:22];
      step(op == OP_PUSH, op == OP_READ, op == OP_BRK, op == OP_FCR, 1'b0, VEC[i][21:14]);
      chk($sformatf("R1 R7 R10 vec%0d level", i), int'(fifo_level), int'(VEC[i][13:9]));
      chk($sformatf("R1 vec%0d trig", i), int'(trig_hit), int'(VEC[i][0]));
      if (op == OP_READ) chk($sformatf("R10 vec%0d read", i), int'(got_rd), int'(VEC[i][8:1]));
    end

    // R1 each trigger depth
    for (int code = 0; code < 4; code++) begin
      int thr;
      thr = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
      step(0, 0, 0, 1, 0, 8'((code << 6) | 3));
      for (int k = 0; k < thr - 1; k++) step(1, 0, 0, 0, 0, 8'(k));
      chk($sformatf("R1 below depth %0d", thr), int'(trig_hit), 0);
      step(1, 0, 0, 0, 0, 8'hC0);
      chk($sformatf("R1 at depth %0d", thr), int'(trig_hit), 1);
    end

    // R11 / R2 full store behaviour
    step(0, 0, 0, 1, 0, 8'h03);
    step(0, 0, 0, 0, 1, 8'h00);
    for (int k = 0; k < 16; k++) step(1, 0, 0, 0, 0, 8'(k));
    chk("R2 filled", int'(fifo_level), 16);
    step(1, 1, 0, 0, 0, 8'h77);
    chk("R11 read head", int'(got_rd), 8'h00);
    chk("R11 level held", int'(fifo_level), 16);
    chk("R11 no overrun", int'(overrun), 0);
    step(1, 0, 0, 0, 0, 8'hEE);
    chk("R2 overrun set", int'(overrun), 1);
    chk("R2 level kept", int'(fifo_level), 16);
    step(0, 1, 0, 0, 0, 8'h00);
    chk("R2 order kept", int'(got_rd), 8'h01);
    for (int k = 0; k < 14; k++) step(0, 1, 0, 0, 0, 8'h00);
    chk("R2 byte 15", int'(got_rd), 8'h0F);
    step(0, 1, 0, 0, 0, 8'h00);
    chk("R2 last is not dropped byte", int'(got_rd), 8'h77);
    chk("R6 empty no data_ready", int'(data_ready), 0);
    step(0, 0, 0, 0, 1, 8'h00);
    chk("R9 overrun cleared", int'(overrun), 0);

    // R7 / R9 / R6 break handling
    step(0, 0, 1, 0, 0, 8'h00);
    chk("R7 break_ind", int'(break_ind), 1);
    chk("R7 data_ready", int'(data_ready), 1);
    step(0, 0, 0, 0, 1, 8'h00);
    chk("R9 break cleared", int'(break_ind), 0);
    step(0, 0, 1, 0, 0, 8'h00);
    step(0, 1, 0, 0, 0, 8'h00);
    chk("R7 null byte", int'(got_rd), 0);
    chk("R6 break held while data", int'(break_ind), 1);
    step(0, 1, 0, 0, 0, 8'h00);
    chk("R6 break cleared on empty", int'(break_ind), 0);

    // R5 / R6 / R3 timeout, char_time = 2 -> 8 cycles
    step(0, 0, 0, 1, 0, 8'h03);
    step(1, 0, 0, 0, 0, 8'h10);
    idle(7);
    chk("R5 not yet", int'(timeout_pend), 0);
    idle(1);
    chk("R5 expired", int'(timeout_pend), 1);
    step(0, 1, 0, 0, 0, 8'h00);
    chk("R6 read clears timeout", int'(timeout_pend), 0);
    step(1, 0, 0, 0, 0, 8'h20);
    idle(5);
    step(1, 0, 0, 0, 0, 8'h21);
    idle(7);
    chk("R5 restart by byte", int'(timeout_pend), 0);
    idle(1);
    chk("R5 expired after restart", int'(timeout_pend), 1);
    step(0, 1, 0, 0, 0, 8'h00);
    idle(7);
    chk("R5 restart by read", int'(timeout_pend), 0);
    idle(1);
    chk("R5 expired after read", int'(timeout_pend), 1);
    step(0, 0, 0, 1, 0, 8'h03);
    chk("R3 flush clears timeout", int'(timeout_pend), 0);
    chk("R3 flush empties", int'(fifo_level), 0);
    step(1, 0, 0, 0, 0, 8'h44);
    rx_valid = 1; rx_data = 8'h45;
    step(1, 0, 0, 1, 0, 8'h03);
    chk("R3 byte with flush dropped", int'(fifo_level), 0);

    // R8 / R4 single-byte mode
    step(1, 0, 0, 0, 0, 8'h99);
    step(0, 0, 0, 1, 0, 8'h00);
    chk("R4 toggle flushes tx", int'(got_tx), 1);
    chk("R4 toggle flushes rx", int'(fifo_level), 0);
    step(1, 0, 0, 0, 0, 8'h5A);
    chk("R8 data_ready", int'(data_ready), 1);
    chk("R8 trig follows data", int'(trig_hit), 1);
    step(1, 0, 0, 0, 0, 8'h6B);
    chk("R8 overrun", int'(overrun), 1);
    chk("R8 one byte", int'(fifo_level), 1);
    idle(20);
    chk("R8 no timeout", int'(timeout_pend), 0);
    step(0, 1, 0, 0, 0, 8'h00);
    chk("R8 first byte kept", int'(got_rd), 8'h5A);
    chk("R8 empty after read", int'(data_ready), 0);
    step(0, 0, 0, 1, 0, 8'h04);
    chk("R4 tx bit", int'(got_tx), 1);
    step(0, 0, 0, 1, 0, 8'h00);
    chk("R4 no tx flush", int'(got_tx), 0);
    chk("R4 still disabled", int'(fifo_on), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule